// File: doc/BRIEF.md
# Four Region Fetch Address Remapper

This block sits on an instruction fetch path and rewrites fetch addresses. It keeps four translation regions, and each region can be switched on or off by itself. A region describes a power-of-two window of 2 MB up to 128 MB, placed by an 8-bit tag that holds address bits 28..21, together with an 11-bit target field that holds output address bits 31..21. An input address whose low 29 bits fall inside the window of an enabled region leaves with the target bits in the upper positions and its own in-window offset in the lower positions. When no enabled region covers the address, it passes through unchanged. Translation is purely combinational. The outputs give a hit flag, the index of the region that won, and two opaque per-region attributes (a route bit and a burst bit) that the block carries through without interpreting them.

Configuration goes through a single write port. A write either loads and enables a region or disables it. The block refuses writes that break the programming rules: it leaves every region register untouched and raises a one-cycle error pulse. The cache-enable state of the surrounding cache arrives as an input and decides whether configuration is allowed.

Top module: `addr_remap`

## Requirements
- R1: After reset all regions are disabled, every address passes through unchanged, hit_o is 0 and cfg_err_o is 0.
- R2: A write with cfg_en_i=1 stores the tag, target, size code, route and burst of region cfg_idx_i and enables it. The write is accepted only when cache_en_i=0, the region is disabled and the size code is nonzero.
- R3: An enabled region with size code c matches when addr_i[28:20+c] equals tag[7:c-1]. addr_i[31:29] is ignored. The output is target[10:c-1] in bits 31:20+c, with addr_i[19+c:0] below.
- R4: Size codes 1..7 give windows of 2, 4, 8, 16, 32, 64 and 128 MB. The first and last byte of the window hit, and the byte just past it does not.
- R5: An address matched by no enabled region appears on addr_o unchanged and hit_o is 0.
- R6: When several enabled regions match, the one with the lowest index is chosen.
- R7: A write while cache_en_i=1 is refused. No region state changes, and cfg_err_o is 1 for exactly the cycle after the write.
- R8: An enabling write to a region that is already enabled is refused, and the region keeps its old settings.
- R9: A write with cfg_en_i=0 disables region cfg_idx_i when cache_en_i=0. After that the region no longer translates.
- R10: An enabling write with size code 0 is refused.
- R11: On a hit, route_o and burst_o carry the winning region's stored attributes. On a miss both are 0.
- R12: On a hit, hit_idx_o gives the winning region's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cache_en_i | input | 1 | Cache enabled; while high all configuration writes are refused |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 2 | Region addressed by the write |
| cfg_en_i | input | 1 | 1 = load and enable, 0 = disable |
| cfg_base_i | input | 8 | Window tag, address bits 28..21 |
| cfg_remap_i | input | 11 | Target, output address bits 31..21 |
| cfg_size_i | input | 3 | Window size code 1..7 |
| cfg_route_i | input | 1 | Opaque route attribute |
| cfg_burst_i | input | 1 | Opaque burst attribute |
| cfg_err_o | output | 1 | One-cycle pulse after a refused write |
| addr_i | input | 32 | Fetch address in |
| addr_o | output | 32 | Translated fetch address |
| hit_o | output | 1 | An enabled region matched |
| hit_idx_o | output | 2 | Index of the winning region |
| route_o | output | 1 | Route attribute of the winning region |
| burst_o | output | 1 | Burst attribute of the winning region |

## Verification
The hardest case to reach is two enabled regions of different sizes whose windows overlap. This is needed to show that the lowest index wins and not the smaller window. The bench gets there by enabling a large window on region 0, placing a small window on region 2 inside it, and then disabling region 0 with the cache off to show that the same address falls to region 2. The window edges for every size code come from re-enabling one region seven times and probing the first byte, the last byte and the byte just past each window.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int unsigned NUM_REGIONS = 4;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned BASE_W      = 8;
  localparam int unsigned REMAP_W     = 11;
  localparam int unsigned SIZE_W      = 3;
  localparam int unsigned IDX_W       = $clog2(NUM_REGIONS);
  localparam int unsigned OFF_LSB     = ADDR_W - REMAP_W;       // 21
  localparam int unsigned BASE_HI     = OFF_LSB + BASE_W - 1;   // 28

  typedef struct packed {
    logic               en;
    logic [SIZE_W-1:0]  size;
    logic [BASE_W-1:0]  base;
    logic [REMAP_W-1:0] remap;
    logic               route;
    logic               burst;
  } region_cfg_t;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
  import remap_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cache_en_i,
  input  logic                        cfg_we_i,
  input  logic [IDX_W-1:0]            cfg_idx_i,
  input  logic                        cfg_en_i,
  input  logic [BASE_W-1:0]           cfg_base_i,
  input  logic [REMAP_W-1:0]          cfg_remap_i,
  input  logic [SIZE_W-1:0]           cfg_size_i,
  input  logic                        cfg_route_i,
  input  logic                        cfg_burst_i,
  output logic                        cfg_err_o,
  output region_cfg_t [NUM_REGIONS-1:0] regs_o
);
  region_cfg_t [NUM_REGIONS-1:0] regs_q;
  logic ok_enable, ok_disable, refused, accept;
  logic err_q;

  assign ok_enable  = !cache_en_i && !regs_q[cfg_idx_i].en && (cfg_size_i != '0);
  assign ok_disable = !cache_en_i;
  assign refused    = cfg_we_i && (cfg_en_i ? !ok_enable : !ok_disable);
  assign accept     = cfg_we_i && !refused;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= refused;
      if (accept) begin
        if (cfg_en_i) begin
          regs_q[cfg_idx_i].en    <= 1'b1;
          regs_q[cfg_idx_i].size  <= cfg_size_i;
          regs_q[cfg_idx_i].base  <= cfg_base_i;
          regs_q[cfg_idx_i].remap <= cfg_remap_i;
          regs_q[cfg_idx_i].route <= cfg_route_i;
          regs_q[cfg_idx_i].burst <= cfg_burst_i;
        end else begin
          regs_q[cfg_idx_i].en <= 1'b0;
        end
      end
    end
  end

  assign cfg_err_o = err_q;
  assign regs_o    = regs_q;

  p_cache_on_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cache_en_i) |=> ($stable(regs_q) && cfg_err_o));
  p_reenable_refused_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_en_i && regs_q[cfg_idx_i].en) |=> $stable(regs_q));
  p_size_zero_refused_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_en_i && cfg_size_i == '0) |=> ($stable(regs_q) && cfg_err_o));
  p_err_needs_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_we_i));
  p_enabled_size_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_q[cfg_idx_i].en |-> regs_q[cfg_idx_i].size != '0);
endmodule

// File: rtl/remap_region_match.sv
module remap_region_match
  import remap_pkg::*;
(
  input  logic               en_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [BASE_W-1:0]  base_i,
  input  logic [REMAP_W-1:0] remap_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               match_o,
  output logic [ADDR_W-1:0]  xlat_o
);
  logic [SIZE_W-1:0] low_bits;     // tag bits dropped from compare
  logic [BASE_W-1:0] tag_diff;
  logic [ADDR_W-1:0] hi_mask;
  logic [ADDR_W-1:0] target_full;

  always_comb begin
    low_bits    = size_i - SIZE_W'(1);
    tag_diff    = (addr_i[BASE_HI:OFF_LSB] ^ base_i) >> low_bits;
    hi_mask     = {ADDR_W{1'b1}} << (OFF_LSB + 32'(low_bits));
    target_full = {remap_i, {OFF_LSB{1'b0}}};
    match_o     = en_i && (size_i != '0) && (tag_diff == '0);
    xlat_o      = (target_full & hi_mask) | (addr_i & ~hi_mask);
  end
endmodule

// File: rtl/remap_prio_sel.sv
module remap_prio_sel
  import remap_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_REGIONS-1:0]         match_i,
  input  logic [NUM_REGIONS-1:0]         en_i,
  input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat_i,
  input  logic [NUM_REGIONS-1:0]         route_i,
  input  logic [NUM_REGIONS-1:0]         burst_i,
  input  logic [ADDR_W-1:0]              addr_i,
  output logic [ADDR_W-1:0]              addr_o,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               hit_idx_o,
  output logic                           route_o,
  output logic                           burst_o
);
  always_comb begin
    addr_o    = addr_i;
    hit_o     = 1'b0;
    hit_idx_o = '0;
    route_o   = 1'b0;
    burst_o   = 1'b0;
    // descending scan: lowest index is assigned last and wins
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        addr_o    = xlat_i[i];
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
        route_o   = route_i[i];
        burst_o   = burst_i[i];
      end
    end
  end

  p_lowest_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_i & ((NUM_REGIONS'(1) << hit_idx_o) - NUM_REGIONS'(1))) == '0));
  p_hit_region_enabled_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> en_i[hit_idx_o]);
  p_miss_attrs_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!route_o && !burst_o));
endmodule

// File: rtl/addr_remap.sv
module addr_remap
  import remap_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cache_en_i,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_en_i,
  input  logic [BASE_W-1:0]  cfg_base_i,
  input  logic [REMAP_W-1:0] cfg_remap_i,
  input  logic [SIZE_W-1:0]  cfg_size_i,
  input  logic               cfg_route_i,
  input  logic               cfg_burst_i,
  output logic               cfg_err_o,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic               route_o,
  output logic               burst_o
);
  region_cfg_t [NUM_REGIONS-1:0]     regs;
  logic [NUM_REGIONS-1:0]            match;
  logic [NUM_REGIONS-1:0]            en_vec, route_vec, burst_vec;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] xlat;

  remap_cfg_regs u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cache_en_i  (cache_en_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_en_i    (cfg_en_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_remap_i (cfg_remap_i),
    .cfg_size_i  (cfg_size_i),
    .cfg_route_i (cfg_route_i),
    .cfg_burst_i (cfg_burst_i),
    .cfg_err_o   (cfg_err_o),
    .regs_o      (regs)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    assign en_vec[g]    = regs[g].en;
    assign route_vec[g] = regs[g].route;
    assign burst_vec[g] = regs[g].burst;
    remap_region_match u_match (
      .en_i    (regs[g].en),
      .size_i  (regs[g].size),
      .base_i  (regs[g].base),
      .remap_i (regs[g].remap),
      .addr_i  (addr_i),
      .match_o (match[g]),
      .xlat_o  (xlat[g])
    );
  end

  remap_prio_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .match_i   (match),
    .en_i      (en_vec),
    .xlat_i    (xlat),
    .route_i   (route_vec),
    .burst_i   (burst_vec),
    .addr_i    (addr_i),
    .addr_o    (addr_o),
    .hit_o     (hit_o),
    .hit_idx_o (hit_idx_o),
    .route_o   (route_o),
    .burst_o   (burst_o)
  );

  p_miss_passthru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> addr_o == addr_i);
  p_offset_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> addr_o[OFF_LSB-1:0] == addr_i[OFF_LSB-1:0]);
  p_disable_stops_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !cfg_en_i && !cache_en_i) |=> !(hit_o && hit_idx_o == $past(cfg_idx_i)));
endmodule

// File: tb/addr_remap_tb.sv
module addr_remap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic        cfg_en = 1'b0;
  logic [7:0]  cfg_base = '0;
  logic [10:0] cfg_remap = '0;
  logic [2:0]  cfg_size = '0;
  logic        cfg_route = 1'b0;
  logic        cfg_burst = 1'b0;
  logic        cfg_err;
  logic [31:0] addr_in = '0;
  logic [31:0] addr_out;
  logic        hit;
  logic [1:0]  hit_idx;
  logic        route, burst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side model of region settings
  bit          m_en[4];
  logic [2:0]  m_size[4];
  logic [7:0]  m_base[4];
  logic [10:0] m_remap[4];
  bit          m_route[4];
  bit          m_burst[4];

  always #5 clk = ~clk;

  addr_remap u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cache_en_i(cache_en),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en),
    .cfg_base_i(cfg_base), .cfg_remap_i(cfg_remap), .cfg_size_i(cfg_size),
    .cfg_route_i(cfg_route), .cfg_burst_i(cfg_burst), .cfg_err_o(cfg_err),
    .addr_i(addr_in), .addr_o(addr_out), .hit_o(hit), .hit_idx_o(hit_idx),
    .route_o(route), .burst_o(burst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input string req, input int idx, input bit en,
                           input logic [7:0] base, input logic [10:0] remap,
                           input logic [2:0] size, input bit rt, input bit bu);
    bit refuse;
    refuse = cache_en || (en && (m_en[idx] || size == 3'd0));
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_en = en; cfg_base = base;
    cfg_remap = remap; cfg_size = size; cfg_route = rt; cfg_burst = bu;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(req, {31'b0, cfg_err}, {31'b0, refuse});
    if (!refuse) begin
      if (en) begin
        m_en[idx] = 1'b1; m_size[idx] = size; m_base[idx] = base;
        m_remap[idx] = remap; m_route[idx] = rt; m_burst[idx] = bu;
      end else m_en[idx] = 1'b0;
    end
  endtask

  task automatic probe(input string req, input logic [31:0] a);
    logic [31:0] e_addr;
    bit e_hit; int e_idx; bit e_rt, e_bu;
    int k, sh;
    logic [31:0] hm;
    e_addr = a; e_hit = 0; e_idx = 0; e_rt = 0; e_bu = 0;
    for (int i = 3; i >= 0; i--) begin
      if (m_en[i]) begin
        k = int'(m_size[i]) - 1;
        sh = 21 + k;
        if ((a[28:21] >> k) == (m_base[i] >> k)) begin
          hm = 32'hFFFF_FFFF << sh;
          e_addr = ({m_remap[i], 21'b0} & hm) | (a & ~hm);
          e_hit = 1; e_idx = i; e_rt = m_route[i]; e_bu = m_burst[i];
        end
      end
    end
    addr_in = a;
    #1;
    chk({req, " addr"}, addr_out, e_addr);
    chk({req, " hit"}, {31'b0, hit}, {31'b0, e_hit});
    if (e_hit) chk({req, " idx R12"}, {30'b0, hit_idx}, 32'(e_idx));
    chk({req, " attr R11"}, {30'b0, route, burst}, {30'b0, e_rt, e_bu});
  endtask

  task automatic t_reset;
    chk("R1 err", {31'b0, cfg_err}, 32'd0);
    probe("R1", 32'h0212_3456);
    probe("R1", 32'hFFFF_FFFF);
  endtask

  task automatic t_basic;
    cfg_write("R2 write", 0, 1, 8'h10, 11'h123, 3'd1, 1, 0);
    addr_in = 32'h0212_3456; #1;
    chk("R3 hand value", addr_out, 32'h2472_3456);
    addr_in = 32'hE212_3456; #1;
    chk("R3 upper bits ignored", addr_out, 32'h2472_3456);
    probe("R3", 32'h021F_FFFF);
    probe("R5 miss", 32'h0232_0000);
    probe("R5 miss below", 32'h01FF_FFFF);
  endtask

  task automatic t_sizes;
    logic [31:0] start, win;
    cfg_write("R9 disable r0", 0, 0, '0, '0, 3'd1, 0, 0);
    probe("R9 after disable", 32'h0212_3456);
    for (int c = 1; c <= 7; c++) begin
      cfg_write("R2 size", 1, 1, 8'hA5, 11'h5A5, 3'(c), c[0], c[1]);
      win   = 32'h1 << (20 + c);
      start = ({3'b0, 8'hA5, 21'b0}) & ~(win - 1);
      probe("R4 first", start);
      chk("R4 first hit", {31'b0, hit}, 32'd1);
      probe("R4 last", start + win - 1);
      chk("R4 last hit", {31'b0, hit}, 32'd1);
      probe("R4 past end", (start + win) & 32'h1FFF_FFFF);
      probe("R4 before", start - 1);
      cfg_write("R9 disable r1", 1, 0, '0, '0, 3'd1, 0, 0);
    end
  endtask

  task automatic t_prio;
    cfg_write("R2 big r0", 0, 1, 8'h40, 11'h7C0, 3'd3, 0, 1);
    cfg_write("R2 small r2", 2, 1, 8'h41, 11'h011, 3'd1, 1, 0);
    probe("R6 overlap", 32'h0820_0010);
    chk("R6 idx", {30'b0, hit_idx}, 32'd0);
    cfg_write("R9 drop r0", 0, 0, '0, '0, 3'd1, 0, 0);
    probe("R6 fallback", 32'h0820_0010);
    chk("R6 fallback idx", {30'b0, hit_idx}, 32'd2);
  endtask

  task automatic t_refuse;
    cfg_write("R8 re-enable r2", 2, 1, 8'h00, 11'h000, 3'd7, 0, 1);
    probe("R8 settings kept", 32'h0820_0010);
    cfg_write("R10 size zero", 3, 1, 8'h00, 11'h3FF, 3'd0, 0, 0);
    probe("R10 no region", 32'h0000_1000);
    cache_en = 1'b1;
    cfg_write("R7 cache on enable", 3, 1, 8'h00, 11'h3FF, 3'd2, 0, 0);
    @(negedge clk);
    chk("R7 single pulse", {31'b0, cfg_err}, 32'd0);
    cfg_write("R9 disable refused", 2, 0, '0, '0, 3'd1, 0, 0);
    probe("R7 state frozen", 32'h0820_0010);
    probe("R7 r3 absent", 32'h0000_1000);
    cache_en = 1'b0;
    cfg_write("R9 disable ok", 2, 0, '0, '0, 3'd1, 0, 0);
    probe("R9 r2 gone", 32'h0820_0010);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_en[i] = 0; m_size[i] = '0; m_base[i] = '0;
      m_remap[i] = '0; m_route[i] = 0; m_burst[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_sizes();
    t_prio();
    t_refuse();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule